// File: doc/BRIEF.md
# I2C Multi-Master Arbitration Guard

This block sits between an I2C master's bit engine and its open-drain pad drivers. It watches the shared SCL and SDA lines through a synchronizer and tracks bus ownership from the START and STOP conditions it observes. It also compares, bit by bit, what this master meant to put on SDA with what the line actually shows. When the master leaves SDA released (a logical 1) on a bit it owns, and the line reads 0 while SCL is high, another master has won. The block then withdraws this master's SDA pull-down at once. It still passes the SCL pull-down through until the current byte's clocks (eight data pulses plus the acknowledge pulse) are complete, and then withdraws that driver as well.

The engine uses `start_grant` to decide when it may issue a START. A grant is given only while the bus is free, which means no START is outstanding and a programmable number of cycles have passed since the last STOP. A one-cycle event and a sticky flag report each lost arbitration to the engine. The flag stays set until the engine clears it.

Top module: `i2c_arb_guard`

## Requirements
- R1: SCL and SDA each pass through SYNC_STAGES (default 2) flops, plus one history flop, before condition detection. With the default setting, a START driven onto the lines is first sampled on clock edge E1 and shows on `bus_busy` after edge E3, but not after edge E2.
- R2: A START (SDA 1→0 while SCL is 1) sets `bus_busy`. A STOP (SDA 0→1 while SCL is 1) clears it. Reset clears it.
- R3: Loss is flagged on any SCL-high cycle where `mst_sda_owned`=1, `mst_sda_pull`=0 and the line reads 0. This applies to every bit position of both the address byte and the data bytes. Both line and intent are seen through equal synchronizer delay.
- R4: From the cycle a loss is detected until a STOP is observed, `sda_pull` is held at 0 whatever `mst_sda_pull` does.
- R5: Each loss raises `arb_lost_pulse` for exactly one cycle and sets `arb_lost_flag`. The flag survives STOP and drops only on a cycle with `lost_clr`=1.
- R6: After a loss, `scl_pull` keeps following `mst_scl_pull` until SCL falls at the end of the 9th SCL pulse of the byte (8 data bits plus acknowledge). From then on it is 0 until a STOP is observed.
- R7: `start_grant` = `start_req` AND `bus_free`. `bus_free` is 1 out of reset. It is 0 while busy and for `free_cycles` cycles after the cycle in which a STOP clears busy. With `free_cycles`=0 it returns in that same cycle.
- R8: Bits with `mst_sda_owned`=0, such as a received acknowledge or read data, never flag a loss, whatever the line level.
- R9: A bit this master pulls low (`mst_sda_pull`=1) never flags a loss. Without a loss, `sda_pull` and `scl_pull` equal the master's requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_line | input | 1 | Raw SCL level from the pad |
| sda_line | input | 1 | Raw SDA level from the pad |
| mst_scl_pull | input | 1 | Engine wants SCL pulled low |
| mst_sda_pull | input | 1 | Engine wants SDA pulled low |
| mst_sda_owned | input | 1 | Current SDA bit is driven by this master (checked for arbitration) |
| start_req | input | 1 | Engine asks to issue a START |
| lost_clr | input | 1 | Clears the sticky lost flag |
| free_cycles | input | FREE_W | Cycles of bus-free time required after STOP |
| scl_pull | output | 1 | Gated SCL pull-down enable to the pad |
| sda_pull | output | 1 | Gated SDA pull-down enable to the pad |
| start_grant | output | 1 | START may be issued now |
| bus_busy | output | 1 | A START has been seen with no STOP since |
| bus_free | output | 1 | Bus idle and free time elapsed |
| arb_lost_pulse | output | 1 | One-cycle lost-arbitration event |
| arb_lost_flag | output | 1 | Sticky lost-arbitration status |

## Verification
The bench places a second master and a slave on the modelled wired-AND lines. It forces losses at a data bit after both masters address the same slave, and at an address bit. A design that checked only the address phase would miss the first loss. A design that cut SCL at once, or one SCL pulse early or late, would stall the winner's byte, and the per-cycle compare would see it. Read data and received acknowledges are driven low on bits the master does not own, to catch a checker that ignores ownership. The case where this master wins by pulling low is also covered. The exact cycle that START latency and free time expire is probed, including zero free time, to expose an off-by-one in the synchronizer depth or in the free counter.

// File: rtl/i2c_arb_pkg.sv
// Package: shared types for the I2C arbitration guard.
// Assumes: nothing beyond IEEE 1800-2017.
package i2c_arb_pkg;

    // Arbitration status bundle passed from the checker to the top level.
    typedef struct packed {
        logic lost_now;   // loss seen in this cycle (combinational)
        logic hold;       // loss latched until STOP
        logic scl_cut;    // SCL driver withdrawn
        logic pulse;      // one-cycle loss event
        logic sticky;     // loss status until cleared
    } arb_stat_t;

    // Width needed to count 0..n inclusive.
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/i2c_sync_pipe.sv
// Module: i2c_sync_pipe
// Multi-flop synchronizer for a small vector of asynchronous levels.
// Assumes: STAGES >= 1; each bit is an independent level (no bus coherency).
module i2c_sync_pipe #(
    parameter int          W       = 2,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/i2c_cond_detect.sv
// Module: i2c_cond_detect
// Derives START, STOP and SCL edges from synchronized line levels.
// Assumes: inputs are already synchronized to clk; idle lines read 1.
module i2c_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_det,
    output logic stop_det,
    output logic scl_rise,
    output logic scl_fall
);

    logic scl_q;
    logic sda_q;

    // Keep one cycle of line history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // SDA edges count as conditions only while SCL stays high.
    always_comb begin
        start_det = scl_s && scl_q && sda_q && !sda_s;
        stop_det  = scl_s && scl_q && !sda_q && sda_s;
        scl_rise  = scl_s && !scl_q;
        scl_fall  = !scl_s && scl_q;
    end

endmodule

// File: rtl/i2c_bus_state.sv
// Module: i2c_bus_state
// Tracks bus ownership from START/STOP and times the post-STOP free window.
// Assumes: start_det and stop_det are never high together.
module i2c_bus_state #(
    parameter int FREE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [FREE_W-1:0] free_cycles,
    output logic              bus_busy,
    output logic              bus_free
);

    logic [FREE_W-1:0] idle_cnt;

    // Busy flag: set by START, cleared by STOP.
    always_ff @(posedge clk) begin
        if (!rst_n)          bus_busy <= 1'b0;
        else if (start_det)  bus_busy <= 1'b1;
        else if (stop_det)   bus_busy <= 1'b0;
    end

    // Free-time counter: restarts on STOP, saturates at the programmed count.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   idle_cnt <= '1;
        else if (stop_det)                            idle_cnt <= '0;
        else if (!bus_busy && idle_cnt < free_cycles) idle_cnt <= idle_cnt + 1'b1;
    end

    // Bus is free once idle and the free window has elapsed.
    always_comb bus_free = !bus_busy && (idle_cnt >= free_cycles);

    assert_start_sets_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> bus_busy);

    assert_stop_clears_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !bus_busy);

    assert_free_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && free_cycles != '0) |=> !bus_free);

endmodule

// File: rtl/i2c_arb_check.sv
// Module: i2c_arb_check
// Bit-level arbitration compare, byte pulse counter and driver withdrawal.
// Assumes: own/pull intents are delayed to match the line synchronizer.
module i2c_arb_check
    import i2c_arb_pkg::*;
#(
    parameter int BYTE_BITS = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      scl_s,
    input  logic      sda_s,
    input  logic      start_det,
    input  logic      stop_det,
    input  logic      scl_rise,
    input  logic      scl_fall,
    input  logic      bus_busy,
    input  logic      own_s,
    input  logic      pull_s,
    input  logic      lost_clr,
    output arb_stat_t stat
);

    localparam int             PULSES = BYTE_BITS + 1;
    localparam int             PW     = cnt_width(PULSES);
    localparam logic [PW-1:0]  LAST   = PW'(PULSES);

    logic [PW-1:0] pulse_idx;
    logic          lost_now;
    logic          hold_q;
    logic          cut_q;
    logic          pulse_q;
    logic          sticky_q;

    // Released-but-low on an owned bit with SCL high means another master won.
    always_comb lost_now = scl_s && own_s && !pull_s && !sda_s && !hold_q;

    // Count SCL pulses within the byte; wraps after the acknowledge pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)                    pulse_idx <= '0;
        else if (start_det || stop_det) pulse_idx <= '0;
        else if (scl_rise && bus_busy) pulse_idx <= (pulse_idx == LAST) ? PW'(1) : pulse_idx + 1'b1;
    end

    // Latch a loss until the bus is released by STOP.
    always_ff @(posedge clk) begin
        if (!rst_n)        hold_q <= 1'b0;
        else if (stop_det) hold_q <= 1'b0;
        else if (lost_now) hold_q <= 1'b1;
    end

    // Withdraw SCL at the falling edge that closes the byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                                         cut_q <= 1'b0;
        else if (stop_det)                                  cut_q <= 1'b0;
        else if (hold_q && scl_fall && pulse_idx == LAST)   cut_q <= 1'b1;
    end

    // One-cycle event for each loss.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= lost_now;
    end

    // Sticky status: a new loss outranks a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        sticky_q <= 1'b0;
        else if (lost_now) sticky_q <= 1'b1;
        else if (lost_clr) sticky_q <= 1'b0;
    end

    always_comb begin
        stat.lost_now = lost_now;
        stat.hold     = hold_q;
        stat.scl_cut  = cut_q;
        stat.pulse    = pulse_q;
        stat.sticky   = sticky_q;
    end

    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q);

    assert_flag_with_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> sticky_q);

    assert_cut_needs_loss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cut_q) |-> hold_q);

    assert_cut_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cut_q) |-> $past(scl_fall));

endmodule

// File: rtl/i2c_arb_guard.sv
// Module: i2c_arb_guard (top)
// Gates an I2C master's open-drain enables on arbitration loss and grants
// START only on a free bus.
// Assumes: pull inputs are active-high pull-down enables; lines read 1 idle.
module i2c_arb_guard
    import i2c_arb_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FREE_W      = 8,
    parameter int BYTE_BITS   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_line,
    input  logic              sda_line,
    input  logic              mst_scl_pull,
    input  logic              mst_sda_pull,
    input  logic              mst_sda_owned,
    input  logic              start_req,
    input  logic              lost_clr,
    input  logic [FREE_W-1:0] free_cycles,
    output logic              scl_pull,
    output logic              sda_pull,
    output logic              start_grant,
    output logic              bus_busy,
    output logic              bus_free,
    output logic              arb_lost_pulse,
    output logic              arb_lost_flag
);

    logic [1:0] line_s;
    logic [1:0] intent_s;
    logic       start_det;
    logic       stop_det;
    logic       scl_rise;
    logic       scl_fall;
    arb_stat_t  stat;

    // Line synchronizer: {scl, sda}, idle high.
    i2c_sync_pipe #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_line_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_line, sda_line}),
        .q     (line_s)
    );

    // Intent delay matched to the line path: {owned, pull}.
    i2c_sync_pipe #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_intent_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({mst_sda_owned, mst_sda_pull}),
        .q     (intent_s)
    );

    i2c_cond_detect u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (line_s[1]),
        .sda_s     (line_s[0]),
        .start_det (start_det),
        .stop_det  (stop_det),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall)
    );

    i2c_bus_state #(.FREE_W(FREE_W)) u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .free_cycles (free_cycles),
        .bus_busy    (bus_busy),
        .bus_free    (bus_free)
    );

    i2c_arb_check #(.BYTE_BITS(BYTE_BITS)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (line_s[1]),
        .sda_s     (line_s[0]),
        .start_det (start_det),
        .stop_det  (stop_det),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_busy  (bus_busy),
        .own_s     (intent_s[1]),
        .pull_s    (intent_s[0]),
        .lost_clr  (lost_clr),
        .stat      (stat)
    );

    // Pad enables: SDA drops in the loss cycle, SCL only at byte end.
    always_comb begin
        sda_pull       = mst_sda_pull && !(stat.lost_now || stat.hold);
        scl_pull       = mst_scl_pull && !stat.scl_cut;
        start_grant    = start_req && bus_free;
        arb_lost_pulse = stat.pulse;
        arb_lost_flag  = stat.sticky;
    end

    assert_sda_off_on_loss_R4: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost_pulse |-> !sda_pull);

endmodule

// File: tb/i2c_arb_guard_test.sv
`timescale 1ns/1ps
module i2c_arb_guard_test;

    localparam int FW = 8;
    localparam int PH = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mst_scl_pull = 1'b0, mst_sda_pull = 1'b0, mst_sda_owned = 1'b0;
    logic          start_req = 1'b0, lost_clr = 1'b0;
    logic [FW-1:0] free_cycles = 8'd6;
    logic          oth_scl = 1'b0, oth_sda = 1'b0;
    bit            oth_act = 1'b0;
    logic          scl_line, sda_line;
    logic          scl_pull, sda_pull, start_grant, bus_busy, bus_free, arb_lost_pulse, arb_lost_flag;

    int n_vec = 0, n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    assign scl_line = !(scl_pull | oth_scl);
    assign sda_line = !(sda_pull | oth_sda);

    i2c_arb_guard #(.SYNC_STAGES(2), .FREE_W(FW), .BYTE_BITS(8)) uut (
        .clk(clk), .rst_n(rst_n), .scl_line(scl_line), .sda_line(sda_line),
        .mst_scl_pull(mst_scl_pull), .mst_sda_pull(mst_sda_pull), .mst_sda_owned(mst_sda_owned),
        .start_req(start_req), .lost_clr(lost_clr), .free_cycles(free_cycles),
        .scl_pull(scl_pull), .sda_pull(sda_pull), .start_grant(start_grant),
        .bus_busy(bus_busy), .bus_free(bus_free),
        .arb_lost_pulse(arb_lost_pulse), .arb_lost_flag(arb_lost_flag)
    );

    // Behavioural reference: line histories in queues, state as integers.
    bit hs[$], hd[$], ho[$], hp[$];
    bit e_busy, e_hold, e_cut, e_pulse, e_sticky;
    int e_idle, e_pc;

    function automatic bit m_lost_now();
        return hs[1] && ho[1] && !hp[1] && !hd[1] && !e_hold;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            hs = '{1, 1, 1}; hd = '{1, 1, 1}; ho = '{0, 0, 0}; hp = '{0, 0, 0};
            e_busy = 0; e_hold = 0; e_cut = 0; e_pulse = 0; e_sticky = 0;
            e_idle = (1 << FW) - 1; e_pc = 0;
        end else begin
            bit ln, st, sp, rs, fl, rs_scl, rs_sda;
            ln = m_lost_now();
            st = hs[1] && hs[2] && hd[2] && !hd[1];
            sp = hs[1] && hs[2] && !hd[2] && hd[1];
            rs = hs[1] && !hs[2];
            fl = !hs[1] && hs[2];
            rs_scl = !((mst_scl_pull && !e_cut) || oth_scl);
            rs_sda = !((mst_sda_pull && !(ln || e_hold)) || oth_sda);
            if (sp) e_idle = 0; else if (!e_busy && e_idle < int'(free_cycles)) e_idle++;
            if (sp) e_cut = 0; else if (e_hold && fl && e_pc == 9) e_cut = 1;
            if (st || sp) e_pc = 0; else if (rs && e_busy) e_pc = (e_pc == 9) ? 1 : e_pc + 1;
            if (st) e_busy = 1; else if (sp) e_busy = 0;
            if (sp) e_hold = 0; else if (ln) e_hold = 1;
            e_pulse = ln;
            if (ln) e_sticky = 1; else if (lost_clr) e_sticky = 0;
            hs.push_front(rs_scl); void'(hs.pop_back());
            hd.push_front(rs_sda); void'(hd.pop_back());
            ho.push_front(mst_sda_owned); void'(ho.pop_back());
            hp.push_front(mst_sda_pull); void'(hp.pop_back());
        end
    end

    task automatic chk(string tag, logic act, logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    // Per-cycle compare at the falling edge, away from input changes.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit ln, fr;
            ln = m_lost_now();
            fr = !e_busy && (e_idle >= int'(free_cycles));
            chk("R4 sda_pull", sda_pull, mst_sda_pull && !(ln || e_hold));
            chk("R6 scl_pull", scl_pull, mst_scl_pull && !e_cut);
            chk("R2 bus_busy", bus_busy, e_busy);
            chk("R7 bus_free", bus_free, fr);
            chk("R7 start_grant", start_grant, start_req && fr);
            chk("R5 arb_lost_pulse", arb_lost_pulse, e_pulse);
            chk("R5 arb_lost_flag", arb_lost_flag, e_sticky);
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic do_start(bit probe);
        mst_sda_owned = 0; mst_sda_pull = 0; oth_sda = 0; tick(PH);
        mst_scl_pull = 0; oth_scl = 0; tick(PH);
        mst_sda_pull = 1; oth_sda = oth_act;
        if (probe) begin
            tick(2); chk("R1 busy not yet", bus_busy, 1'b0);
            tick(1); chk("R1 busy after sync", bus_busy, 1'b1);
            tick(PH - 3);
        end else tick(PH);
        mst_scl_pull = 1; oth_scl = oth_act; tick(PH);
    endtask

    task automatic do_bit(bit mp, bit op, bit own);
        mst_sda_pull = mp; oth_sda = op; mst_sda_owned = own; tick(PH);
        mst_scl_pull = 0; oth_scl = 0; tick(PH);
        mst_scl_pull = 1; oth_scl = oth_act; tick(PH);
    endtask

    task automatic do_byte(bit [7:0] mb, bit [7:0] ob, bit ack_low);
        for (int i = 7; i >= 0; i--) do_bit(!mb[i], !ob[i], 1'b1);
        do_bit(1'b0, ack_low, 1'b0);
    endtask

    task automatic read_byte(bit [7:0] db);
        for (int i = 7; i >= 0; i--) do_bit(1'b0, !db[i], 1'b0);
        do_bit(1'b1, 1'b0, 1'b1);
    endtask

    task automatic do_stop();
        mst_sda_owned = 0; mst_sda_pull = 1; oth_sda = oth_act; tick(PH);
        mst_scl_pull = 0; oth_scl = 0; tick(PH);
        mst_sda_pull = 0; oth_sda = 0; tick(2 * PH);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(20ns * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        tick(4);
        chk("R2 busy in reset", bus_busy, 1'b0);
        chk("R5 flag in reset", arb_lost_flag, 1'b0);
        rst_n = 1; tick(1);
        start_req = 1; tick(1);
        chk("R7 free out of reset", start_grant, 1'b1);
        start_req = 0;

        // Solo write, slave acknowledges on bits the master does not own.
        do_start(1'b1);
        do_byte(8'hA0, 8'hFF, 1'b1);
        do_byte(8'h5A, 8'hFF, 1'b1);
        start_req = 1;
        do_stop();
        chk("R7 held during free time", start_grant, 1'b0);
        tick(1);
        chk("R7 granted after free time", start_grant, 1'b1);
        chk("R9 no loss solo", arb_lost_flag, 1'b0);
        start_req = 0;

        // Read: low data bits driven by the slave are not owned.
        do_start(1'b0);
        do_byte(8'hA1, 8'hFF, 1'b1);
        read_byte(8'h00);
        read_byte(8'h36);
        do_stop();
        chk("R8 no loss on unowned bits", arb_lost_flag, 1'b0);
        tick(10);

        // Two masters, same address, diverging in the data byte.
        oth_act = 1;
        do_start(1'b0);
        do_byte(8'hA0, 8'hA0, 1'b1);
        chk("R3 no loss while equal", arb_lost_flag, 1'b0);
        do_byte(8'hA5, 8'hA1, 1'b1);
        chk("R3 loss in data phase", arb_lost_flag, 1'b1);
        mst_scl_pull = 1;
        chk("R6 SCL withdrawn at byte end", scl_pull, 1'b0);
        do_stop();
        chk("R5 flag survives STOP", arb_lost_flag, 1'b1);
        chk("R6 SCL back after STOP", scl_pull, mst_scl_pull);
        lost_clr = 1; tick(1); lost_clr = 0;
        chk("R5 flag cleared", arb_lost_flag, 1'b0);
        tick(10);

        // Loss in the address byte.
        do_start(1'b0);
        do_byte(8'h78, 8'h58, 1'b1);
        chk("R3 loss in address phase", arb_lost_flag, 1'b1);
        do_byte(8'h00, 8'h33, 1'b1);
        do_stop();
        lost_clr = 1; tick(1); lost_clr = 0;
        tick(10);

        // This master pulls low where the other releases: it wins.
        do_start(1'b0);
        do_byte(8'h58, 8'h78, 1'b1);
        chk("R9 pulling master keeps bus", arb_lost_flag, 1'b0);
        do_stop();
        oth_act = 0;

        // Zero free time: grant returns with the busy clear.
        free_cycles = 8'd0;
        do_start(1'b0);
        do_byte(8'hC4, 8'hFF, 1'b1);
        start_req = 1;
        do_stop();
        chk("R7 zero free time", start_grant, 1'b1);
        chk("R9 no loss solo", arb_lost_flag, 1'b0);
        start_req = 0;
        tick(4);
        finish_run();
    end

endmodule